// File: doc/BRIEF.md
# Fast Transfer Address Remapper

This block sits on the CPU side of a game cartridge. It watches a slow, 6502-style bus: the address lines A14..A0, the ROM select strobe (which stands in for A15), the read/write line and the M2 phase clock. From these it produces the upper address bits of the cartridge work RAM. It also drives two handshake lines to a separate counter block that addresses video-side memory. A fast synchronous clock samples M2, delays it by a few clocks and finds its edges. Commands take effect only at the rising edge of that delayed M2, so the ROM select strobe has settled by then.

Software issues commands by reading from addresses, not by writing data. A read from the $42xx page picks a 4 KB bank for the $6000-$6FFF window from the low address byte and turns fast transfer on. A read from the $43xx page turns fast transfer off. In fast transfer each window cycle is split in two. While M2 is low the RAM sees the banked source address, and the byte on the bus is handed to the video side by a low pulse on the write strobe. While M2 is high every upper RAM bit is forced to one, so the CPU executes code from the top page of RAM at the same low byte.

A build parameter selects one of three transfer variants. The plain split variant copies a byte on every window fetch. The parity variant accepts a fetch only when its address parity is the opposite of the last accepted one, so a refetched byte is not copied twice. The paired variant alternates a banked, capturing access with a remapped access that does not capture.

Top module: `xfr_remap`

## Requirements
- R1: While reset is high and after it is released, the bank is 0, fast transfer is off, `wppu_n` and `control_n` are 1, and `ram_hi` is 0 for an address outside $6000-$7FFF.
- R2: `ram_hi` carries RAM address bits [BANK_W+11:8], and A7..A0 reach the RAM directly without passing through the block. When fast transfer is off, $6xxx maps to {bank, A11..A8}, $7xxx maps to {all ones, A11..A8}, and any other address gives 0.
- R3: A read in $4200-$42FF with `romsel_n` high loads bank = A[BANK_W-1:0] and turns fast transfer on. `control_n` stays low for as long as fast transfer is on.
- R4: A read in $4300-$43FF with `romsel_n` high turns fast transfer off. After that, a window access is no longer remapped and no longer captured.
- R5: A write to a command page is ignored, and so is any access made while `romsel_n` is low. Bank and mode change only at the rising edge of the delayed M2.
- R6: In the split and parity variants with fast transfer on, a read in $6000-$7FFF gives the normal mapping while M2 is low and gives `ram_hi` all ones while M2 is high.
- R7: With fast transfer on, each accepted read in $6000-$6FFF produces exactly one low pulse on `wppu_n`, WPPU_LEN clocks long, after the delayed M2 rises. A read in $7xxx produces no pulse, and no access produces a pulse while fast transfer is off.
- R8: In the parity variant, a capture is accepted only when A0 differs from the A0 of the last accepted capture. The first capture after fast transfer is turned on is always accepted.
- R9: In the paired variant, window reads alternate starting from the first one after fast transfer is turned on. The first access of each pair is banked in both M2 halves and captures. The second is all ones in both halves and does not capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| m2 | input | 1 | CPU phase clock, asynchronous to clk |
| cpu_a | input | 15 | CPU address A14..A0 |
| cpu_rd | input | 1 | 1 for a read cycle |
| romsel_n | input | 1 | ROM select strobe, low for $8000-$FFFF while M2 is high |
| ram_hi | output | BANK_W+4 | Upper work RAM address bits |
| wppu_n | output | 1 | Active-low byte strobe to the video-side counter |
| control_n | output | 1 | Low while fast transfer is on |

## Verification
The bench builds three copies of the block side by side, with BANK_W=3, M2_DLY=2 and WPPU_LEN=3: one in the split variant, one in the parity variant and one in the paired variant. The three copies share the same bus stimulus. With a 3-bit bank, all eight banks can be crossed with all sixteen 256-byte pages of the window. Comparing the three variants on one refetching address sequence shows each acceptance rule against the same inputs. Every strobe pulse is counted per cycle and its width is measured.

// File: rtl/xfr_pkg.sv
package xfr_pkg;
  localparam int XM_SPLIT  = 0;
  localparam int XM_PARITY = 1;
  localparam int XM_PAIR   = 2;
  localparam logic [6:0] PG_LOAD = 7'h42;
  localparam logic [6:0] PG_STOP = 7'h43;
endpackage

// File: rtl/xfr_m2_sync.sv
module xfr_m2_sync #(
  parameter int M2_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic m2,
  output logic m2_q,
  output logic rise,
  output logic fall
);
  localparam int STAGES = M2_DLY + 2;
  logic [STAGES-1:0] sh;
  logic prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh   <= '0;
      prev <= 1'b0;
    end else begin
      sh   <= {sh[STAGES-2:0], m2};
      prev <= sh[STAGES-1];
    end
  end

  assign m2_q = sh[STAGES-1];
  assign rise = m2_q & ~prev;
  assign fall = ~m2_q & prev;
endmodule

// File: rtl/xfr_cmd_decode.sv
module xfr_cmd_decode
  import xfr_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise,
  input  logic [14:0]       cpu_a,
  input  logic              cpu_rd,
  input  logic              romsel_n,
  output logic [BANK_W-1:0] bank,
  output logic              fast
);
  logic act;
  logic unused_low;
  assign act = rise & cpu_rd & romsel_n;
  assign unused_low = ^cpu_a[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      bank <= '0;
      fast <= 1'b0;
    end else if (act && cpu_a[14:8] == PG_LOAD) begin
      bank <= cpu_a[BANK_W-1:0];
      fast <= 1'b1;
    end else if (act && cpu_a[14:8] == PG_STOP) begin
      fast <= 1'b0;
    end
  end

  // R5: commands only at the delayed M2 rise
  assert_cmd_at_rise_R5: assert property (@(posedge clk) disable iff (rst)
    !rise |=> ($stable(bank) && $stable(fast)));
  // R4: stop page clears the mode
  assert_stop_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (act && cpu_a[14:8] == PG_STOP) |=> !fast);
endmodule

// File: rtl/xfr_xfer_ctrl.sv
module xfr_xfer_ctrl
  import xfr_pkg::*;
#(
  parameter int XFER_MODE = XM_SPLIT,
  parameter int WPPU_LEN  = 3
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rise,
  input  logic        fall,
  input  logic        m2_q,
  input  logic        fast,
  input  logic [14:0] cpu_a,
  input  logic        cpu_rd,
  input  logic        romsel_n,
  output logic        force_hi,
  output logic        wppu_n
);
  localparam int CW = $clog2(WPPU_LEN + 1);
  logic in_win, capt, accept;
  logic [CW-1:0] cnt;
  logic unused_sig;

  assign in_win     = cpu_rd & (cpu_a[14:13] == 2'b11);
  assign capt       = rise & fast & in_win & romsel_n & ~cpu_a[12];
  assign unused_sig = fall ^ cpu_a[0];

  generate
    if (XFER_MODE == XM_PARITY) begin : g_parity
      logic have, last;
      assign accept   = ~have | (cpu_a[0] != last);
      assign force_hi = fast & in_win & m2_q;
      always_ff @(posedge clk) begin
        if (rst || !fast) begin
          have <= 1'b0;
          last <= 1'b0;
        end else if (capt && accept) begin
          have <= 1'b1;
          last <= cpu_a[0];
        end
      end
    end else if (XFER_MODE == XM_PAIR) begin : g_pair
      logic ph, hit_q;
      assign accept   = ~ph;
      assign force_hi = fast & in_win & ph;
      always_ff @(posedge clk) begin
        if (rst || !fast) begin
          ph    <= 1'b0;
          hit_q <= 1'b0;
        end else if (rise) begin
          hit_q <= in_win & romsel_n;
        end else if (fall && hit_q) begin
          ph    <= ~ph;
          hit_q <= 1'b0;
        end
      end
      // R9: the pair phase moves only at the end of a bus cycle
      assert_pair_phase_R9: assert property (@(posedge clk) disable iff (rst)
        (fast && !fall) |=> ($stable(ph) || !fast));
    end else begin : g_split
      assign accept   = 1'b1;
      assign force_hi = fast & in_win & m2_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      wppu_n <= 1'b1;
    end else begin
      if (capt && accept) cnt <= CW'(WPPU_LEN);
      else if (cnt != '0) cnt <= cnt - 1'b1;
      wppu_n <= (cnt == '0);
    end
  end

  // R7: a strobe only starts while fast transfer is on
  assert_strobe_fast_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(wppu_n) |-> $past(fast));
  generate
    if (WPPU_LEN > 1) begin : g_wchk
      // R7: strobe is wider than one clock
      assert_strobe_width_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(wppu_n) |=> !wppu_n);
    end
  endgenerate
endmodule

// File: rtl/xfr_addr_map.sv
module xfr_addr_map #(
  parameter int BANK_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [6:0]        a_hi,
  input  logic [BANK_W-1:0] bank,
  input  logic              force_hi,
  output logic [BANK_W+3:0] ram_hi
);
  always_ff @(posedge clk) begin
    if (rst)                    ram_hi <= '0;
    else if (a_hi[6:5] != 2'b11) ram_hi <= '0;
    else if (force_hi)          ram_hi <= '1;
    else if (a_hi[4])           ram_hi <= {{BANK_W{1'b1}}, a_hi[3:0]};
    else                        ram_hi <= {bank, a_hi[3:0]};
  end

  // R2: outside the window the upper bits are zero
  assert_outside_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (a_hi[6:5] != 2'b11) |=> (ram_hi == '0));
endmodule

// File: rtl/xfr_remap.sv
module xfr_remap
  import xfr_pkg::*;
#(
  parameter int BANK_W    = 4,
  parameter int M2_DLY    = 2,
  parameter int WPPU_LEN  = 3,
  parameter int XFER_MODE = XM_SPLIT
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              m2,
  input  logic [14:0]       cpu_a,
  input  logic              cpu_rd,
  input  logic              romsel_n,
  output logic [BANK_W+3:0] ram_hi,
  output logic              wppu_n,
  output logic              control_n
);
  logic m2_q, rise, fall, fast, force_hi;
  logic [BANK_W-1:0] bank;

  xfr_m2_sync #(.M2_DLY(M2_DLY)) u_sync (
    .clk(clk), .rst(rst), .m2(m2), .m2_q(m2_q), .rise(rise), .fall(fall));

  xfr_cmd_decode #(.BANK_W(BANK_W)) u_cmd (
    .clk(clk), .rst(rst), .rise(rise), .cpu_a(cpu_a), .cpu_rd(cpu_rd),
    .romsel_n(romsel_n), .bank(bank), .fast(fast));

  xfr_xfer_ctrl #(.XFER_MODE(XFER_MODE), .WPPU_LEN(WPPU_LEN)) u_ctrl (
    .clk(clk), .rst(rst), .rise(rise), .fall(fall), .m2_q(m2_q), .fast(fast),
    .cpu_a(cpu_a), .cpu_rd(cpu_rd), .romsel_n(romsel_n),
    .force_hi(force_hi), .wppu_n(wppu_n));

  xfr_addr_map #(.BANK_W(BANK_W)) u_map (
    .clk(clk), .rst(rst), .a_hi(cpu_a[14:8]), .bank(bank),
    .force_hi(force_hi), .ram_hi(ram_hi));

  assign control_n = ~fast;
endmodule

// File: tb/xfr_remap_tb.sv
module xfr_remap_tb_top;
  localparam int BW = 3;
  localparam int HW = BW + 4;
  localparam int HALF = 16;
  localparam int LEN = 3;
  localparam logic [HW-1:0] ONES = '1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m2 = 1'b0;
  logic [14:0] cpu_a = '0;
  logic cpu_rd = 1'b1;
  logic romsel_n = 1'b1;
  logic [HW-1:0] ram_s, ram_p, ram_q;
  logic wp_s, wp_p, wp_q, cn_s, cn_p, cn_q;
  int errors = 0, checks = 0, cyc = 0;
  int n_s = 0, n_p = 0, n_q = 0, wlen = 0;
  logic pv_s = 1'b1, pv_p = 1'b1, pv_q = 1'b1;
  logic [HW-1:0] lo_s, lo_p, lo_q, hi_s, hi_p, hi_q;

  always #2.5 clk = ~clk;

  xfr_remap #(.BANK_W(BW), .M2_DLY(2), .WPPU_LEN(LEN), .XFER_MODE(0)) dut_i (
    .clk(clk), .rst(rst), .m2(m2), .cpu_a(cpu_a), .cpu_rd(cpu_rd),
    .romsel_n(romsel_n), .ram_hi(ram_s), .wppu_n(wp_s), .control_n(cn_s));
  xfr_remap #(.BANK_W(BW), .M2_DLY(2), .WPPU_LEN(LEN), .XFER_MODE(1)) dut_p_i (
    .clk(clk), .rst(rst), .m2(m2), .cpu_a(cpu_a), .cpu_rd(cpu_rd),
    .romsel_n(romsel_n), .ram_hi(ram_p), .wppu_n(wp_p), .control_n(cn_p));
  xfr_remap #(.BANK_W(BW), .M2_DLY(2), .WPPU_LEN(LEN), .XFER_MODE(2)) dut_q_i (
    .clk(clk), .rst(rst), .m2(m2), .cpu_a(cpu_a), .cpu_rd(cpu_rd),
    .romsel_n(romsel_n), .ram_hi(ram_q), .wppu_n(wp_q), .control_n(cn_q));

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (pv_s && !wp_s) n_s++;
    if (pv_p && !wp_p) n_p++;
    if (pv_q && !wp_q) n_q++;
    if (!wp_s) wlen++;
    if (!pv_s && wp_s) begin
      chk(wlen == LEN, "R7 strobe width", wlen, LEN);
      wlen = 0;
    end
    pv_s = wp_s; pv_p = wp_p; pv_q = wp_q;
    if (cyc == 150000) begin
      chk(1'b0, "watchdog", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic bus(input logic [15:0] ad, input logic rd);
    @(negedge clk);
    m2 = 1'b0; cpu_a = ad[14:0]; cpu_rd = rd; romsel_n = 1'b1;
    repeat (HALF - 1) @(negedge clk);
    lo_s = ram_s; lo_p = ram_p; lo_q = ram_q;
    @(negedge clk);
    m2 = 1'b1; romsel_n = ~ad[15];
    repeat (HALF - 1) @(negedge clk);
    hi_s = ram_s; hi_p = ram_p; hi_q = ram_q;
  endtask

  initial begin
    int b0, b1, b2;
    logic [HW-1:0] e;
    repeat (5) @(negedge clk);
    chk(wp_s && cn_s && wp_p && cn_q, "R1 idle strobes in reset", {wp_s, cn_s}, 3);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk(ram_s == 0 && ram_q == 0, "R1 ram_hi after reset", ram_s, 0);
    chk(wp_s && cn_s, "R1 strobes after reset", {wp_s, cn_s}, 3);

    // R2: normal mapping with bank 0
    for (int p = 0; p < 16; p++) begin
      b0 = n_s;
      bus(16'h6000 | 16'(p << 8) | 16'h11, 1'b1);
      e = {BW'(0), 4'(p)};
      chk(lo_s == e && hi_s == e, "R2 window $6xxx", hi_s, e);
      bus(16'h7000 | 16'(p << 8), 1'b1);
      e = {{BW{1'b1}}, 4'(p)};
      chk(lo_s == e && hi_s == e, "R2 window $7xxx", hi_s, e);
      chk(n_s == b0, "R7 no strobe when off", n_s - b0, 0);
    end
    bus(16'h5123, 1'b1);
    chk(lo_s == 0 && hi_s == 0, "R2 outside window", hi_s, 0);

    // R5: ignored commands
    bus(16'h4205, 1'b0);
    chk(cn_s == 1'b1, "R5 write to load page", cn_s, 1);
    bus(16'hC206, 1'b1);
    chk(cn_s == 1'b1, "R5 romsel low", cn_s, 1);
    bus(16'h6300, 1'b1);
    chk(hi_s == {BW'(0), 4'd3}, "R5 bank unchanged", hi_s, {BW'(0), 4'd3});

    // R3 R6 R7: sweep every bank over every page
    for (int b = 0; b < 8; b++) begin
      bus(16'h4200 | 16'((b * 24 + b) & 8'hF8) | 16'(b), 1'b1);
      chk(cn_s == 1'b0, "R3 control_n low", cn_s, 0);
      for (int p = 0; p < 16; p++) begin
        b0 = n_s;
        bus(16'h6000 | 16'(p << 8) | 16'(p * 7), 1'b1);
        e = {BW'(b), 4'(p)};
        chk(lo_s == e, "R6 banked in M2 low", lo_s, e);
        chk(hi_s == ONES, "R6 forced in M2 high", hi_s, ONES);
        chk(n_s == b0 + 1, "R7 one strobe per fetch", n_s - b0, 1);
      end
      b0 = n_s;
      bus(16'h7A20, 1'b1);
      chk(lo_s == {{BW{1'b1}}, 4'hA} && hi_s == ONES, "R6 $7xxx in fast", hi_s, ONES);
      chk(n_s == b0, "R7 no strobe for $7xxx", n_s - b0, 0);
      chk(cn_s == 1'b0, "R3 control_n held", cn_s, 0);
    end

    // R4: stop
    bus(16'h43AB, 1'b1);
    chk(cn_s == 1'b1, "R4 control_n high", cn_s, 1);
    b0 = n_s;
    bus(16'h6500, 1'b1);
    chk(hi_s == {BW'(7), 4'd5}, "R4 no remap after stop", hi_s, {BW'(7), 4'd5});
    chk(n_s == b0, "R4 no strobe after stop", n_s - b0, 0);

    // R8 R9: refetch sequence across the variants
    bus(16'h4202, 1'b1);
    for (int k = 0; k < 5; k++) begin
      logic [15:0] ad;
      int ep;
      ad = (k == 0) ? 16'h6200 : (k <= 2) ? 16'h6201 : 16'h6200 | 16'(k - 1);
      b0 = n_s; b1 = n_p; b2 = n_q;
      bus(ad, 1'b1);
      ep = (k == 2) ? 0 : 1;
      chk(n_s == b0 + 1, "R7 split strobes every fetch", n_s - b0, 1);
      chk(n_p == b1 + ep, "R8 parity acceptance", n_p - b1, ep);
      chk(n_q == b2 + ((k % 2 == 0) ? 1 : 0), "R9 pair capture", n_q - b2, (k % 2 == 0));
      e = (k % 2 == 0) ? {BW'(2), 4'd2} : ONES;
      chk(lo_q == e && hi_q == e, "R9 pair address", {lo_q, hi_q}, {e, e});
      chk(lo_p == {BW'(2), 4'd2} && hi_p == ONES, "R6 parity split", hi_p, ONES);
    end
    bus(16'h4300, 1'b1);
    bus(16'h4201, 1'b1);
    b1 = n_p;
    bus(16'h6100, 1'b1);
    bus(16'h6102, 1'b1);
    chk(n_p == b1 + 1, "R8 first after re-enable then same parity", n_p - b1, 1);
    bus(16'h6103, 1'b1);
    chk(n_p == b1 + 2, "R8 opposite parity", n_p - b1, 2);
    bus(16'h4300, 1'b1);
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule